// File: doc/BRIEF.md
# Serial Dual-Channel Gain Control Register

This block is the control side of a two-channel digitally stepped amplifier. A host reaches it over a four-wire serial link (active-low select, clock, data in, data out) and uses it to set and read back, for each of two channels, a 6-bit gain code and a channel-on bit. The serial pins are brought into a faster system clock through two-flop synchronisers, and all edge detection happens in that clock domain.

Every access is a fixed 16-bit frame. It opens with a command byte that holds a read flag, six reserved bits and a channel-select bit. A data byte follows: on a write it holds the new settings, and on a read the data out line returns the selected register. A write lands only when the select line rises after exactly sixteen clocks. A frame that is shorter or longer is thrown away. Each channel's effective enable is its register bit ANDed with an external enable pin, so a board-level pin can shut a channel off quickly while its gain code is kept.

Top module: `spi_gain_regs`

## Requirements
- R1: After reset both channel registers hold on-bit 1 and gain code 0, and the data-out enable is low.
- R2: A 16-bit write frame updates only the channel it selects. Bits go MSB first. Frame bit 15 is the read flag (0 = write, 1 = read), bits 14..9 are reserved, and bit 8 selects the channel (0 = A, 1 = B). Data bit 7 is the on-bit, bits 6..1 are the gain code (weights 16, 8, 4, 2, 1, 0.5 dB from bit 6 down), and bit 0 is reserved.
- R3: A frame closed after fewer than 16 clocks writes nothing.
- R4: A frame closed after more than 16 clocks writes nothing.
- R5: In a read frame, data out presents the selected register as {on-bit, gain[5:0], 0}, MSB first. Each bit changes on one of the falling clock edges 8 to 15, counted from 1, so the host samples it on the following rising edge.
- R6: The data-out enable is high exactly while the synchronised select line is low.
- R7: A channel's active output is its register on-bit ANDed with its enable pin.
- R8: A channel's gain code is held while the channel is inactive. Outside a committed write it never changes.
- R9: A write takes effect on the rising edge of the select line, not at the 16th clock.
- R10: Each fall of the select line starts a fresh frame, so a full frame that follows an aborted one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock; data in is sampled on rising edges |
| spi_csn_i | input | 1 | Active-low frame select |
| spi_sdi_i | input | 1 | Serial data in |
| pin_en_i | input | 2 | Channel enable pins, bit 0 = A, bit 1 = B |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdo_oe_o | output | 1 | Output enable for serial data out |
| gain_a_o | output | 6 | Channel A gain code |
| gain_b_o | output | 6 | Channel B gain code |
| act_a_o | output | 1 | Channel A effective enable |
| act_b_o | output | 1 | Channel B effective enable |

## Verification
The bench first writes different codes to each channel. It reads both back to tell a correct channel decode from a swapped or shared register, and to confirm the bit order on data out. It then sends frames of 10 and 17 clocks carrying a write that would be visible, which separates the exact-length commit rule from a check that only counts a minimum number of clocks. Writes of the on-bit alone, and toggles of the enable pins alone, each turn a channel off, which tells the AND gate apart from either input on its own. Per-clock comparison shows gain codes held through disables and unchanged until the select line rises.

// File: rtl/spi_gain_pkg.sv
package spi_gain_pkg;
  localparam int NCH = 2;
  typedef enum logic {CMD_WRITE = 1'b0, CMD_READ = 1'b1} spi_cmd_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q, chain_d;
    always_comb chain_d = {chain_q[STAGES-2:0], d_i[b]};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= chain_d;
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_gain_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_rise_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sdi_i,
  output logic              wr_stb_o,
  output logic              wr_addr_o,
  output logic [DATA_W-2:0] wr_data_o,
  output logic              hdr_done_o,
  output logic              hdr_read_o,
  output logic              hdr_addr_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-2:0] shf_q, shf_d;
  spi_cmd_e          cmd_q, cmd_d;
  logic              addr_q, addr_d;
  logic              take;

  assign take = !csn_i && sck_rise_i;

  always_comb begin
    cnt_d  = cnt_q;
    shf_d  = shf_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    if (cs_fall_i) begin
      // R10: every new select starts from an empty frame
      cnt_d  = '0;
      shf_d  = '0;
      cmd_d  = CMD_WRITE;
      addr_d = 1'b0;
    end else if (take) begin
      if (cnt_q != CNT_MAX)  cnt_d = cnt_q + 1'b1;    // R4: saturates past a full frame
      if (cnt_q < CNT_LAST)  shf_d = {shf_q[DATA_W-3:0], sdi_i};
      if (cnt_q == '0)       cmd_d = spi_cmd_e'(sdi_i);
      if (cnt_q == CNT_HDR)  addr_d = sdi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      shf_q  <= '0;
      cmd_q  <= CMD_WRITE;
      addr_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      shf_q  <= shf_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
    end
  end

  // R3/R4/R9: commit only at select release after exactly FRAME_W clocks
  assign wr_stb_o   = cs_rise_i && (cnt_q == CNT_FULL) && (cmd_q == CMD_WRITE);
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = shf_q;
  assign hdr_done_o = take && (cnt_q == CNT_HDR);
  assign hdr_read_o = (cmd_q == CMD_READ);
  assign hdr_addr_o = sdi_i;
  assign bit_cnt_o  = cnt_q;
endmodule

// File: rtl/spi_ctl_bank.sv
module spi_ctl_bank #(
  parameter int NCH = 2,
  parameter int CW  = 7,
  parameter int AW  = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_stb_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [CW-1:0]           wr_data_i,
  output logic [NCH-1:0][CW-1:0]  ctl_o
);
  // R1: on-bit set, gain code zero
  localparam logic [CW-1:0] RST_CTL = {1'b1, {(CW-1){1'b0}}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CW-1:0] ctl_q, ctl_d;
    logic          sel;
    assign sel = wr_stb_i && (wr_addr_i == AW'(ch));
    always_comb ctl_d = sel ? wr_data_i : ctl_q;   // R8: hold otherwise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctl_q <= RST_CTL;
      else         ctl_q <= ctl_d;
    end
    assign ctl_o[ch] = ctl_q;
  end
endmodule

// File: rtl/spi_sdo_tx.sv
module spi_sdo_tx #(
  parameter int NCH     = 2,
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5,
  parameter int AW      = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       csn_i,
  input  logic                       cs_fall_i,
  input  logic                       sck_fall_i,
  input  logic                       hdr_done_i,
  input  logic                       hdr_read_i,
  input  logic [AW-1:0]              hdr_addr_i,
  input  logic [CNT_W-1:0]           bit_cnt_i,
  input  logic [NCH-1:0][DATA_W-2:0] ctl_i,
  output logic                       sdo_o
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              sdo_q, sdo_d;
  logic              shift_en;

  assign shift_en = !csn_i && sck_fall_i &&
                    (bit_cnt_i >= CNT_W'(DATA_W)) && (bit_cnt_i <= CNT_W'(FRAME_W - 1));

  always_comb begin
    tx_d  = tx_q;
    sdo_d = sdo_q;
    if (cs_fall_i) begin
      tx_d  = '0;
      sdo_d = 1'b0;
    end else if (hdr_done_i) begin
      // R5: readback byte {on, gain, 0}
      tx_d = hdr_read_i ? {ctl_i[hdr_addr_i], 1'b0} : '0;
    end else if (shift_en) begin
      sdo_d = tx_q[DATA_W-1];
      tx_d  = {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/spi_gain_regs.sv
module spi_gain_regs
  import spi_gain_pkg::*;
#(
  parameter int GAIN_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sck_i,
  input  logic              spi_csn_i,
  input  logic              spi_sdi_i,
  input  logic [1:0]        pin_en_i,
  output logic              spi_sdo_o,
  output logic              spi_sdo_oe_o,
  output logic [GAIN_W-1:0] gain_a_o,
  output logic [GAIN_W-1:0] gain_b_o,
  output logic              act_a_o,
  output logic              act_b_o
);
  localparam int DATA_W  = GAIN_W + 2;
  localparam int CW      = DATA_W - 1;
  localparam int FRAME_W = 2 * DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int AW      = 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // synchronisers: bit 0 sck, bit 1 csn, bit 2 sdi
  logic [2:0] pins_s;
  spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_n),
    .d_i   ({spi_sdi_i, spi_csn_i, spi_sck_i}),
    .q_o   (pins_s)
  );

  logic sck_s, csn_s, sdi_s;
  assign sck_s = pins_s[0];
  assign csn_s = pins_s[1];
  assign sdi_s = pins_s[2];

  logic sck_prev_q, csn_prev_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      csn_prev_q <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      csn_prev_q <= csn_s;
    end
  end

  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_prev_q;
  assign sck_fall = ~sck_s & sck_prev_q;
  assign cs_fall  = ~csn_s & csn_prev_q;
  assign cs_rise  = csn_s & ~csn_prev_q;

  logic             wr_stb, wr_addr, hdr_done, hdr_read, hdr_addr;
  logic [CW-1:0]    wr_data;
  logic [CNT_W-1:0] bit_cnt;

  spi_frame_rx #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk_i     (clk_i),   .rst_ni    (rst_n),
    .csn_i     (csn_s),   .sck_rise_i(sck_rise),
    .cs_fall_i (cs_fall), .cs_rise_i (cs_rise),
    .sdi_i     (sdi_s),
    .wr_stb_o  (wr_stb),  .wr_addr_o (wr_addr), .wr_data_o(wr_data),
    .hdr_done_o(hdr_done), .hdr_read_o(hdr_read), .hdr_addr_o(hdr_addr),
    .bit_cnt_o (bit_cnt)
  );

  logic [NCH-1:0][CW-1:0] ctl;

  spi_ctl_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u_bank (
    .clk_i    (clk_i),  .rst_ni   (rst_n),
    .wr_stb_i (wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ctl_o    (ctl)
  );

  spi_sdo_tx #(.NCH(NCH), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .AW(AW)) u_tx (
    .clk_i     (clk_i),    .rst_ni    (rst_n),
    .csn_i     (csn_s),    .cs_fall_i (cs_fall), .sck_fall_i(sck_fall),
    .hdr_done_i(hdr_done), .hdr_read_i(hdr_read), .hdr_addr_i(hdr_addr),
    .bit_cnt_i (bit_cnt),  .ctl_i     (ctl),
    .sdo_o     (spi_sdo_o)
  );

  assign spi_sdo_oe_o = ~csn_s;                       // R6
  assign gain_a_o     = ctl[0][GAIN_W-1:0];
  assign gain_b_o     = ctl[1][GAIN_W-1:0];
  assign act_a_o      = ctl[0][CW-1] & pin_en_i[0];   // R7
  assign act_b_o      = ctl[1][CW-1] & pin_en_i[1];
endmodule

// File: rtl/spi_gain_regs_chk.sv
module spi_gain_regs_chk #(
  parameter int GAIN_W  = 6,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spi_csn_i,
  input logic [1:0]        pin_en_i,
  input logic              spi_sdo_oe_o,
  input logic [GAIN_W-1:0] gain_a_o,
  input logic [GAIN_W-1:0] gain_b_o,
  input logic              act_a_o,
  input logic              act_b_o,
  input logic              wr_stb,
  input logic [CNT_W-1:0]  bit_cnt
);
  assert_commit_full_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |-> (bit_cnt == CNT_W'(FRAME_W)));

  assert_count_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_W + 1));

  assert_gain_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb |=> ($stable(gain_a_o) && $stable(gain_b_o)));

  assert_pin_gates_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_en_i[0] |-> !act_a_o);

  assert_pin_gates_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_en_i[1] |-> !act_b_o);

  assert_oe_follows_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sdo_oe_o |-> !$past(spi_csn_i, 2));
endmodule

bind spi_gain_regs spi_gain_regs_chk #(.GAIN_W(GAIN_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .spi_csn_i   (spi_csn_i),
  .pin_en_i    (pin_en_i),
  .spi_sdo_oe_o(spi_sdo_oe_o),
  .gain_a_o    (gain_a_o),
  .gain_b_o    (gain_b_o),
  .act_a_o     (act_a_o),
  .act_b_o     (act_b_o),
  .wr_stb      (wr_stb),
  .bit_cnt     (bit_cnt)
);

// File: tb/spi_gain_regs_bench.sv
module spi_gain_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;   // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [1:0] pin = 2'b11;
  logic       sdo, sdo_oe, act_a, act_b;
  logic [5:0] gain_a, gain_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_gain_regs u_spi_gain_regs (
    .clk_i(clk), .rst_ni(rst_n), .spi_sck_i(sck), .spi_csn_i(csn), .spi_sdi_i(sdi),
    .pin_en_i(pin), .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe),
    .gain_a_o(gain_a), .gain_b_o(gain_b), .act_a_o(act_a), .act_b_o(act_b)
  );

  int   vectors = 0, errors = 0;
  bit   mon_en = 1'b0, done = 1'b0;
  logic exp_en [2];
  int   exp_gain [2];
  logic csn_h1 = 1'b1, csn_h2 = 1'b1;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    csn_h2 <= csn_h1;
    csn_h1 <= csn;
  end

  // per-clock comparison against the model
  always @(negedge clk) if (mon_en) begin
    chk("R2 gain A", gain_a, exp_gain[0]);
    chk("R2 gain B", gain_b, exp_gain[1]);
    chk("R7 act A", act_a, exp_en[0] & pin[0]);
    chk("R7 act B", act_b, exp_en[1] & pin[1]);
    chk("R6 sdo_oe", sdo_oe, !csn_h2);
  end

  task automatic frame(input logic [15:0] word, input int nbits, output logic [7:0] rd);
    int a;
    a  = word[8];
    rd = '0;
    @(posedge clk); #1 csn = 1'b0;
    repeat (HALF) @(posedge clk); #1;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b0;
      repeat (HALF) @(posedge clk); #1;
      if (i >= 8 && i < 16) rd = {rd[6:0], sdo};
      sck = 1'b1;
      repeat (HALF) @(posedge clk); #1;
      sck = 1'b0;
    end
    repeat (HALF) @(posedge clk); #1;
    if (nbits == 16 && !word[15])
      chk("R9 gain before select release", a ? gain_b : gain_a, exp_gain[a]);
    csn = 1'b1;
    repeat (3) @(posedge clk);
    if (nbits == 16 && !word[15]) begin
      exp_en[a]   = word[7];
      exp_gain[a] = int'(word[6:1]);
    end
    repeat (HALF) @(posedge clk); #1;
  endtask

  task automatic wr(input int ch, input logic en, input int g);
    logic [7:0] unused_rd;
    frame({7'b0, ch[0], en, g[5:0], 1'b0}, 16, unused_rd);
  endtask

  task automatic rd_chk(input int ch, input string tag);
    logic [7:0] r;
    logic [7:0] e;
    e = {exp_en[ch], 6'(exp_gain[ch]), 1'b0};
    frame({8'h80 | 8'(ch[0]), 8'h00}, 16, r);
    chk(tag, r, e);
  endtask

  task automatic set_pins(input logic [1:0] v);
    @(posedge clk); #1 pin = v;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    logic [7:0] junk;
    exp_en[0] = 1'b1; exp_en[1] = 1'b1;
    exp_gain[0] = 0;  exp_gain[1] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R1 reset gain A", gain_a, 0);
    chk("R1 reset gain B", gain_b, 0);
    chk("R1 reset act A", act_a, 1);
    chk("R1 reset act B", act_b, 1);
    chk("R1 reset sdo_oe", sdo_oe, 0);
    mon_en = 1'b1;

    wr(0, 1'b1, 6'h2A);                       // R2 channel A only
    chk("R2 A written", gain_a, 6'h2A);
    chk("R2 B untouched", gain_b, 0);
    wr(1, 1'b1, 6'h15);
    chk("R2 B written", gain_b, 6'h15);
    rd_chk(0, "R5 readback A");
    rd_chk(1, "R5 readback B");

    frame({8'h00, 1'b1, 6'h3F, 1'b0}, 10, junk); // R3 short frame
    chk("R3 short frame ignored", gain_a, 6'h2A);
    frame({8'h00, 1'b1, 6'h3F, 1'b0}, 17, junk); // R4 long frame
    chk("R4 long frame ignored", gain_a, 6'h2A);
    rd_chk(0, "R4 readback after long frame");

    frame({8'h01, 1'b1, 6'h07, 1'b0}, 5, junk);  // R10 aborted then full
    wr(1, 1'b1, 6'h09);
    chk("R10 fresh frame accepted", gain_b, 6'h09);

    wr(1, 1'b0, 6'h33);                        // R7/R8 register disable
    chk("R7 reg off gates B", act_b, 0);
    chk("R8 gain kept while off", gain_b, 6'h33);
    rd_chk(1, "R5 readback disabled B");

    set_pins(2'b10);                            // R7/R8 pin disable
    chk("R7 pin off gates A", act_a, 0);
    chk("R8 gain kept pin off", gain_a, 6'h2A);
    set_pins(2'b11);
    chk("R7 pin on restores A", act_a, 1);
    wr(1, 1'b1, 6'h33);
    chk("R7 both on B", act_b, 1);

    wr(0, 1'b1, 6'h3F);                         // extremes
    rd_chk(0, "R5 readback max");
    wr(0, 1'b1, 6'h01);
    rd_chk(0, "R5 readback lsb");

    mon_en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule